// File: doc/BRIEF.md
# Full-Expansion Partial Distance Unit

This block expands a single node of a breadth-first tree-search MIMO detector that works on the real-valued model of the channel. For one parent node it computes, in parallel, the partial Euclidean distance of every child. There is one child for each real constellation level of the selected modulation. The distance of a child is the parent's accumulated distance plus the squared error `(y - intf - r * s)^2`. Here `y` is the rotated received sample for the level, `r` is the diagonal coefficient of the triangular factor, `intf` is the interference already summed from symbols decided higher in the tree, and `s` is the child's level value.

No child is pruned. Every candidate is forwarded with its symbol value and a per-slot valid bit, so a later stage can sort or select among them. At the root the parent distance is driven to zero. For example, eight copies working side by side on the root's eight children of a 64-QAM tree produce the 64 distances of the next level. The modulation can be changed on every input beat. The datapath is a fixed three-stage pipeline that accepts one node per clock.

Top module: `ped_expand`

## Requirements
- R1: For every valid slot, `out_dist` equals `parent_dist + (y_in - intf_in - r_diag * s)^2`, where `s` is that slot's symbol. All inputs are two's-complement signed except `parent_dist` and the distances, which are unsigned.
- R2: A distance whose exact value exceeds the largest unsigned value of `DW` bits is output as all ones. It never wraps, so a valid slot's distance is never below its parent distance.
- R3: The `mode` encoding selects the number of real levels per dimension: 0 selects 2 (4-QAM), 1 selects 4 (16-QAM), 2 selects 8 (64-QAM), and 3 also selects 8.
- R4: With L levels, slot j for j < L carries the symbol `2*j - (L-1)`, written as a signed 4-bit field at bits `[4*j+3:4*j]` of `out_sym`. Bit j of `out_slot_valid` is set for those slots only.
- R5: Slots at or above L have `out_slot_valid` bit 0, symbol 0 and distance all ones, so that no minimum search can pick them.
- R6: Each accepted input (`in_valid` high) produces exactly one result, with `out_valid` high, three rising clock edges later. Inputs may arrive on consecutive cycles, and results keep their order.
- R7: While reset is asserted (`rst_n` low), and afterwards until the first result is due, `out_valid` and every bit of `out_slot_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A node is presented this cycle |
| parent_dist | input | DW | Accumulated distance of the parent (unsigned) |
| y_in | input | YW | Rotated received sample for this level (signed) |
| r_diag | input | RW | Diagonal triangular-factor coefficient (signed) |
| intf_in | input | YW | Interference sum from decided symbols (signed) |
| mode | input | 2 | Modulation select, see R3 |
| out_valid | output | 1 | Result present this cycle |
| out_dist | output | NCH*DW | Child distances, slot j at `[DW*j +: DW]` |
| out_sym | output | NCH*4 | Child symbols, signed 4-bit per slot |
| out_slot_valid | output | NCH | Per-slot candidate valid |

## Verification
The saturation corner of R2 is the hardest case to reach. It occurs only when a large parent distance meets a large error, and with random small operands it almost never happens. The stimulus reaches it directly in two ways: a parent one step below full scale paired with a small nonzero error, and a parent of zero paired with extreme `r_diag`, `y_in` and `intf_in` values of opposite signs, whose outer-level error alone overflows. Mode changes on back-to-back beats exercise the R4 and R5 slot masks while the pipeline is full.

// File: rtl/ped_pkg.sv
package ped_pkg;

  localparam int SYMW = 4;

  typedef enum logic [1:0] {
    QAM4      = 2'd0,
    QAM16     = 2'd1,
    QAM64     = 2'd2,
    QAM64_ALT = 2'd3
  } qam_mode_e;

  // Number of real amplitude levels per dimension for a mode code (R3).
  function automatic int unsigned levels_of(input logic [1:0] m);
    case (m)
      QAM4:    return 2;
      QAM16:   return 4;
      default: return 8;
    endcase
  endfunction

  // Odd-integer level of slot j among lv levels (R4).
  function automatic logic signed [SYMW-1:0] level_sym(input int unsigned lv,
                                                       input int unsigned j);
    int t;
    t = 2 * int'(j) - int'(lv) + 1;
    return SYMW'(t);
  endfunction

endpackage

// File: rtl/ped_level_gen.sv
module ped_level_gen
  import ped_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic [1:0]          mode,
  output logic [NCH*SYMW-1:0] sym_flat,
  output logic [NCH-1:0]      slot_ok
);

  int unsigned lv;
  assign lv = levels_of(mode);

  for (genvar j = 0; j < NCH; j++) begin : g_slot
    always_comb begin
      slot_ok[j] = (j < lv);
      sym_flat[j*SYMW +: SYMW] = slot_ok[j] ? level_sym(lv, j) : '0;
    end
  end

endmodule

// File: rtl/ped_err_lane.sv
module ped_err_lane
  import ped_pkg::*;
#(
  parameter int YW = 16,
  parameter int RW = 16,
  parameter int EW = 22
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic signed [YW:0]     base,
  input  logic signed [RW-1:0]   r_coef,
  input  logic signed [SYMW-1:0] sym,
  output logic signed [EW-1:0]   err_q
);

  localparam int PW = RW + SYMW;

  logic signed [PW-1:0] prod;
  logic signed [EW-1:0] err_d;

  assign prod  = r_coef * sym;
  assign err_d = EW'(base) - EW'(prod);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= '0;
    else        err_q <= err_d;
  end

endmodule

// File: rtl/ped_sq_lane.sv
module ped_sq_lane #(
  parameter int EW = 22,
  parameter int DW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [EW-1:0] err,
  input  logic [DW-1:0]        parent,
  input  logic                 ok,
  output logic [DW-1:0]        dist_q
);

  localparam int QW = 2 * EW;
  localparam int SW = ((QW > DW) ? QW : DW) + 1;

  logic signed [QW-1:0] sq_s;
  logic [SW-1:0]        sum;
  logic                 over;
  logic [DW-1:0]        dist_d;

  assign sq_s   = err * err;
  assign sum    = SW'($unsigned(sq_s)) + SW'(parent);
  assign over   = |sum[SW-1:DW];
  assign dist_d = (!ok || over) ? '1 : sum[DW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dist_q <= '0;
    else        dist_q <= dist_d;
  end

endmodule

// File: rtl/ped_expand.sv
module ped_expand
  import ped_pkg::*;
#(
  parameter int NCH = 8,
  parameter int YW  = 16,
  parameter int RW  = 16,
  parameter int DW  = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [DW-1:0]        parent_dist,
  input  logic signed [YW-1:0] y_in,
  input  logic signed [RW-1:0] r_diag,
  input  logic signed [YW-1:0] intf_in,
  input  logic [1:0]           mode,
  output logic                 out_valid,
  output logic [NCH*DW-1:0]    out_dist,
  output logic [NCH*SYMW-1:0]  out_sym,
  output logic [NCH-1:0]       out_slot_valid
);

  localparam int PW = RW + SYMW;
  localparam int EW = ((YW + 1 > PW) ? YW + 1 : PW) + 1;

  // Candidate generation (combinational from mode)
  logic [NCH*SYMW-1:0] gen_sym;
  logic [NCH-1:0]      gen_ok;

  ped_level_gen #(.NCH(NCH)) u_gen (
    .mode     (mode),
    .sym_flat (gen_sym),
    .slot_ok  (gen_ok)
  );

  // Stage 1: residual before the diagonal term
  logic                 s1_valid;
  logic [DW-1:0]        s1_parent;
  logic signed [YW:0]   s1_base;
  logic signed [RW-1:0] s1_r;
  logic [NCH*SYMW-1:0]  s1_sym;
  logic [NCH-1:0]       s1_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      s1_parent <= '0;
      s1_base   <= '0;
      s1_r      <= '0;
      s1_sym    <= '0;
      s1_ok     <= '0;
    end else begin
      s1_valid  <= in_valid;
      s1_parent <= parent_dist;
      s1_base   <= (YW+1)'(y_in) - (YW+1)'(intf_in);
      s1_r      <= r_diag;
      s1_sym    <= gen_sym;
      s1_ok     <= in_valid ? gen_ok : '0;
    end
  end

  // Stage 2: per-child error
  logic                 s2_valid;
  logic [DW-1:0]        s2_parent;
  logic [NCH*SYMW-1:0]  s2_sym;
  logic [NCH-1:0]       s2_ok;
  logic signed [EW-1:0] s2_err [NCH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_valid  <= 1'b0;
      s2_parent <= '0;
      s2_sym    <= '0;
      s2_ok     <= '0;
    end else begin
      s2_valid  <= s1_valid;
      s2_parent <= s1_parent;
      s2_sym    <= s1_sym;
      s2_ok     <= s1_ok;
    end
  end

  for (genvar j = 0; j < NCH; j++) begin : g_lane
    ped_err_lane #(.YW(YW), .RW(RW), .EW(EW)) u_err (
      .clk    (clk),
      .rst_n  (rst_n),
      .base   (s1_base),
      .r_coef (s1_r),
      .sym    (s1_sym[j*SYMW +: SYMW]),
      .err_q  (s2_err[j])
    );

    // Stage 3: square, accumulate, saturate
    ped_sq_lane #(.EW(EW), .DW(DW)) u_sq (
      .clk    (clk),
      .rst_n  (rst_n),
      .err    (s2_err[j]),
      .parent (s2_parent),
      .ok     (s2_ok[j]),
      .dist_q (out_dist[j*DW +: DW])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid      <= 1'b0;
      out_sym        <= '0;
      out_slot_valid <= '0;
    end else begin
      out_valid      <= s2_valid;
      out_sym        <= s2_sym;
      out_slot_valid <= s2_ok;
    end
  end

endmodule

// File: rtl/ped_expand_chk.sv
module ped_expand_chk
  import ped_pkg::*;
#(
  parameter int NCH = 8,
  parameter int DW  = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [DW-1:0]       parent_dist,
  input logic [1:0]          mode,
  input logic                s1_valid,
  input logic                s2_valid,
  input logic                out_valid,
  input logic [NCH*DW-1:0]   out_dist,
  input logic [NCH*SYMW-1:0] out_sym,
  input logic [NCH-1:0]      out_slot_valid
);

  a_r6_stage1: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid == $past(in_valid));
  a_r6_stage2: assert property (@(posedge clk) disable iff (!rst_n)
    s2_valid == $past(s1_valid));
  a_r6_stage3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(s2_valid));

  a_r7_idle_mask: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> out_slot_valid == '0);

  a_r3_count: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones(out_slot_valid) ==
      (($past(mode, 3) == 2'd0) ? 2 : ($past(mode, 3) == 2'd1) ? 4 : 8));

  a_r4_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
    (out_slot_valid & (out_slot_valid + 1'b1)) == '0);

  for (genvar j = 0; j < NCH; j++) begin : g_chk
    a_r2_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_slot_valid[j]) |->
        out_dist[j*DW +: DW] >= $past(parent_dist, 3));
    a_r5_unused: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_slot_valid[j]) |->
        (out_dist[j*DW +: DW] == '1 && out_sym[j*SYMW +: SYMW] == '0));
  end

endmodule

bind ped_expand ped_expand_chk #(.NCH(NCH), .DW(DW)) u_chk (.*);

// File: tb/ped_expand_test.sv
module ped_expand_test;

  localparam int NCH = 8;
  localparam int DW  = 32;
  localparam longint unsigned DMAX = 64'h0000_0000_FFFF_FFFF;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               in_valid = 1'b0;
  logic [DW-1:0]      parent_dist = '0;
  logic signed [15:0] y_in = '0;
  logic signed [15:0] r_diag = '0;
  logic signed [15:0] intf_in = '0;
  logic [1:0]         mode = '0;
  logic               out_valid;
  logic [NCH*DW-1:0]  out_dist;
  logic [NCH*4-1:0]   out_sym;
  logic [NCH-1:0]     out_slot_valid;

  ped_expand uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .parent_dist(parent_dist),
    .y_in(y_in), .r_diag(r_diag), .intf_in(intf_in), .mode(mode),
    .out_valid(out_valid), .out_dist(out_dist), .out_sym(out_sym),
    .out_slot_valid(out_slot_valid)
  );

  always #10 clk = ~clk;

  typedef struct packed {
    logic [NCH*DW-1:0] d;
    logic [NCH*4-1:0]  s;
    logic [NCH-1:0]    ok;
    int                issued;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic exp_t model(longint unsigned p, int y, int r, int f, int m);
    exp_t x;
    int lv;
    lv = (m == 0) ? 2 : (m == 1) ? 4 : 8;
    x = '0;
    for (int j = 0; j < NCH; j++) begin
      if (j < lv) begin
        int s;
        longint e;
        longint unsigned tot;
        s   = 2 * j - (lv - 1);
        e   = longint'(y) - longint'(f) - longint'(r) * longint'(s);
        tot = p + longint'(e * e);
        if (tot > DMAX) tot = DMAX;
        x.d[j*DW +: DW] = tot[DW-1:0];
        x.s[j*4 +: 4]   = s[3:0];
        x.ok[j]         = 1'b1;
      end else begin
        x.d[j*DW +: DW] = '1;
      end
    end
    return x;
  endfunction

  task automatic check(bit good, string req, string what, longint act, longint expv);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic drive(longint unsigned p, int y, int r, int f, int m);
    exp_t x;
    @(negedge clk);
    in_valid    = 1'b1;
    parent_dist = p[DW-1:0];
    y_in        = 16'(y);
    r_diag      = 16'(r);
    intf_in     = 16'(f);
    mode        = 2'(m);
    x = model(p, y, r, f, m);
    x.issued = cyc;
    q.push_back(x);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      y_in     = 16'sh1234;
      mode     = 2'd2;
    end
  endtask

  // Monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && !done) begin
        if (q.size() > 0 && !out_valid && cyc - q[0].issued >= 3)
          check(1'b0, "R6", "missing result, age", cyc - q[0].issued, 3);
        if (out_valid) begin
          if (q.size() == 0) begin
            check(1'b0, "R6", "unexpected out_valid", 1, 0);
          end else begin
            exp_t x;
            x = q.pop_front();
            check(cyc - x.issued == 3, "R6", "latency", cyc - x.issued, 3);
            check(out_slot_valid == x.ok, "R4", "slot mask", out_slot_valid, x.ok);
            for (int j = 0; j < NCH; j++) begin
              check(out_sym[j*4 +: 4] == x.s[j*4 +: 4], "R4", $sformatf("symbol slot %0d", j),
                    out_sym[j*4 +: 4], x.s[j*4 +: 4]);
              check(out_dist[j*DW +: DW] == x.d[j*DW +: DW],
                    x.ok[j] ? "R1/R2" : "R5", $sformatf("distance slot %0d", j),
                    out_dist[j*DW +: DW], x.d[j*DW +: DW]);
            end
          end
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      check(1'b0, "WDOG", "run did not finish, cycle", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R7: reset state
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R7", "out_valid in reset", out_valid, 0);
    check(out_slot_valid == '0, "R7", "slot mask in reset", out_slot_valid, 0);
    rst_n = 1'b1;
    idle(2);
    check(out_valid == 1'b0, "R7", "out_valid after reset", out_valid, 0);

    // R1/R3/R4: root node, each mode
    drive(0, 100, 10, 20, 2);
    drive(0, -300, 45, 7, 1);
    drive(0, 5, -3, -9, 0);
    drive(0, 77, 11, 0, 3);
    idle(4);
    // R1: nonzero parent, back-to-back with mode changes (R6, R5)
    drive(1000, -1234, 321, 456, 2);
    drive(55555, 32767, -32768, -32768, 0);
    drive(7, 0, 0, 0, 1);
    drive(123456789, -20000, 300, 10000, 3);
    drive(42, 1, 1, 1, 0);
    idle(1);
    // R2: saturation corners
    drive(64'hFFFF_FFFE, 10, 1, 0, 2);
    drive(0, -32768, 32767, 32767, 2);
    drive(64'hFFFF_FFFF, 0, 0, 0, 0);
    drive(64'hFFFF_0000, 200, 1, 0, 1);
    // R6: a stream of results
    for (int i = 0; i < 12; i++)
      drive(i * 1000, i * 97 - 500, 13 + i, -i * 31, i % 4);
    idle(6);
    check(q.size() == 0, "R6", "leftover expected results", q.size(), 0);
    check(out_valid == 1'b0 && out_slot_valid == '0, "R7", "idle outputs", out_slot_valid, 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule